// File: doc/BRIEF.md
# Row-Local Spare Remapper

This block tracks, for every row of a two-dimensional array of identical processing elements, where each logical element of that row currently sits. Each row is built with a fixed number of physical positions. The highest-numbered positions start out as idle spares. When a permanent fault is reported at a given row and physical column, that position is retired. Every logical element of the same row that sat to the right of it moves one position further right and takes up one of that row's spares. No other row changes its placement, so one fault costs one spare element and not a whole column.

Data may travel between elements in any direction. Once two neighbouring rows have been shifted by different amounts, a vertical link no longer joins elements that sit in the same physical column. For each physical position the block therefore drives a retire (bypass) select and two signed vertical offsets. These tell the switch fabric how many positions left or right the partner element lies in the row above and in the row below. When a fault arrives in a row whose spares are all used up, a sticky device-failure flag is raised. Fault detection and the switch fabric itself are outside this block.

Top module: `row_spare_remap`

## Requirements
- R1: While reset is asserted, and until the first accepted fault after reset, all bypass selects and vertical offsets are 0 and the failure flag is low.
- R2: A fault report (fault_vld high) at row r and column c, on a position that is not yet retired, in a row that still has a spare, sets bypass_sel bit r*COLS+c from the next clock edge. A set bit never clears before reset.
- R3: A fault report changes the bypass selects of its own row only. The vertical offsets of rows that are neither that row nor directly adjacent to it stay unchanged.
- R4: In every row, logical element k (0 to COLS-SPARES-1) occupies the k-th non-retired physical position counting from column 0. Elements left of a new fault keep their position and elements right of it move one position right.
- R5: vlink_up field (r*COLS+p)*OW, OW bits wide and two's complement, holds P_up - p. Here P_up is the physical position of the same logical element in row r-1 and p holds that element in row r. The field is 0 in row 0 and at positions that are retired or hold no logical element.
- R6: vlink_dn uses the same field layout and the same rule with row r+1 in place of row r-1. It is 0 in the last row.
- R7: Up to SPARES faults in one row, on distinct positions, are absorbed without raising the failure flag, including when they arrive on consecutive cycles.
- R8: A fault on a non-retired position in a row that already has SPARES retired positions raises dev_failed on the next edge and leaves every bypass select unchanged. dev_failed stays high until reset.
- R9: A repeated report for an already retired position is ignored: no output changes and no spare is used.
- R10: A report whose row is at least ROWS or whose column is at least COLS is ignored.
- R11: A fault on a spare position that holds no logical element retires that position and uses up one spare without moving any logical element.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| fault_vld | input | 1 | Fault report strobe, one report per cycle |
| fault_row | input | $clog2(ROWS) | Row of the reported fault |
| fault_col | input | $clog2(COLS) | Physical column of the reported fault |
| bypass_sel | output | ROWS*COLS | Retire/bypass select per physical position, bit r*COLS+c |
| vlink_up | output | ROWS*COLS*OW | Signed offset to the partner in the row above, per position |
| vlink_dn | output | ROWS*COLS*OW | Signed offset to the partner in the row below, per position |
| dev_failed | output | 1 | Sticky flag: a fault could not be absorbed |

## Verification
Two functions can act on the same clock edge. One is the update of a row's placement together with the offsets of its two neighbouring rows. The other is the failure detection that must refuse a fault in a row whose spares are gone. The bench sends the report that uses a row's last spare and, on the very next cycle, a report that must fail in the same row. It also sends three faults in one row on consecutive cycles and faults in adjacent rows one after the other. A behavioural model of the per-row placement is compared on every cycle against all four outputs, so a refused fault that still moves the placement, or an offset that is one cycle late, is reported on that cycle.

// File: rtl/rsr_pkg.sv
package rsr_pkg;

  // Index width helper: at least one bit even for a count of one.
  function automatic int idx_w(input int n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

  // Default array shape.
  localparam int DEF_ROWS   = 6;
  localparam int DEF_COLS   = 6;
  localparam int DEF_SPARES = 3;

endpackage

// File: rtl/rsr_rst_sync.sv
module rsr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;

  // Assert at once, release after two edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/rsr_row_state.sv
module rsr_row_state #(
  parameter int COLS   = 6,
  parameter int SPARES = 3,
  parameter int CW     = 3,
  parameter int SW     = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hit,
  input  logic [CW-1:0]   col,
  output logic [COLS-1:0] retired,
  output logic            refuse
);

  logic [COLS-1:0] ret_q, ret_d;
  logic [SW-1:0]   used_q, used_d;
  logic            fresh, full, upd_en;

  // Next-state: a fresh fault either consumes a spare or is refused.
  always_comb begin
    fresh  = hit && !ret_q[col];
    full   = (used_q == SW'(SPARES));
    refuse = fresh && full;
    upd_en = fresh && !full;
    ret_d  = ret_q;
    used_d = used_q;
    if (upd_en) begin
      ret_d[col] = 1'b1;
      used_d     = used_q + SW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ret_q  <= '0;
      used_q <= '0;
    end else if (upd_en) begin
      ret_q  <= ret_d;
      used_q <= used_d;
    end
  end

  assign retired = ret_q;

endmodule

// File: rtl/rsr_row_map.sv
module rsr_row_map #(
  parameter int COLS  = 6,
  parameter int LCOLS = 3,
  parameter int CW    = 3
) (
  input  logic [COLS-1:0]     retired,
  output logic [COLS-1:0]     active,
  output logic [COLS*CW-1:0]  lidx,
  output logic [LCOLS*CW-1:0] lpos
);

  // Walk the row left to right; the k-th surviving position holds logical k.
  always_comb begin
    int seen;
    seen   = 0;
    active = '0;
    lidx   = '0;
    lpos   = '0;
    for (int p = 0; p < COLS; p++) begin
      if (!retired[p]) begin
        if (seen < LCOLS) begin
          active[p]              = 1'b1;
          lidx[p*CW +: CW]       = CW'(seen);
          lpos[seen*CW +: CW]    = CW'(p);
        end
        seen = seen + 1;
      end
    end
  end

endmodule

// File: rtl/rsr_vlink.sv
module rsr_vlink #(
  parameter int COLS   = 6,
  parameter int LCOLS  = 3,
  parameter int CW     = 3,
  parameter int OW     = 3,
  parameter int HAS_NB = 1
) (
  input  logic [COLS-1:0]     active,
  input  logic [COLS*CW-1:0]  lidx,
  input  logic [LCOLS*CW-1:0] nb_lpos,
  output logic [COLS*OW-1:0]  offs
);

  // Offset = neighbour position of the same logical element minus own position.
  always_comb begin
    int k;
    int nbp;
    offs = '0;
    for (int p = 0; p < COLS; p++) begin
      k   = int'(lidx[p*CW +: CW]);
      nbp = 0;
      if (k < LCOLS) begin
        nbp = int'(nb_lpos[k*CW +: CW]);
      end
      if ((HAS_NB != 0) && active[p]) begin
        offs[p*OW +: OW] = OW'(nbp - p);
      end
    end
  end

endmodule

// File: rtl/row_spare_remap.sv
module row_spare_remap
  import rsr_pkg::*;
#(
  parameter int ROWS   = DEF_ROWS,
  parameter int COLS   = DEF_COLS,
  parameter int SPARES = DEF_SPARES,
  localparam int RW    = idx_w(ROWS),
  localparam int CW    = idx_w(COLS),
  localparam int SW    = idx_w(SPARES + 1),
  localparam int OW    = SW + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    fault_vld,
  input  logic [RW-1:0]           fault_row,
  input  logic [CW-1:0]           fault_col,
  output logic [ROWS*COLS-1:0]    bypass_sel,
  output logic [ROWS*COLS*OW-1:0] vlink_up,
  output logic [ROWS*COLS*OW-1:0] vlink_dn,
  output logic                    dev_failed
);

  localparam int LCOLS = COLS - SPARES;

  logic                rst_i_n;
  logic                row_ok, col_ok;
  logic [ROWS-1:0]     row_hit;
  logic [ROWS-1:0]     row_refuse;
  logic [COLS-1:0]     ret_w    [ROWS];
  logic [COLS-1:0]     act_w    [ROWS];
  logic [COLS*CW-1:0]  lidx_w   [ROWS];
  logic [LCOLS*CW-1:0] lpos_w   [ROWS];
  logic                fail_q, fail_d, fail_en;

  rsr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  // Range qualification of the report.
  always_comb begin
    row_ok = ({1'b0, fault_row} < (RW+1)'(ROWS));
    col_ok = ({1'b0, fault_col} < (CW+1)'(COLS));
  end

  genvar r;
  generate
    for (r = 0; r < ROWS; r++) begin : g_row
      assign row_hit[r] = fault_vld && row_ok && col_ok && (fault_row == RW'(r));

      rsr_row_state #(
        .COLS   (COLS),
        .SPARES (SPARES),
        .CW     (CW),
        .SW     (SW)
      ) u_state (
        .clk     (clk),
        .rst_n   (rst_i_n),
        .hit     (row_hit[r]),
        .col     (fault_col),
        .retired (ret_w[r]),
        .refuse  (row_refuse[r])
      );

      rsr_row_map #(
        .COLS  (COLS),
        .LCOLS (LCOLS),
        .CW    (CW)
      ) u_map (
        .retired (ret_w[r]),
        .active  (act_w[r]),
        .lidx    (lidx_w[r]),
        .lpos    (lpos_w[r])
      );

      assign bypass_sel[r*COLS +: COLS] = ret_w[r];
    end

    for (r = 0; r < ROWS; r++) begin : g_link
      rsr_vlink #(
        .COLS   (COLS),
        .LCOLS  (LCOLS),
        .CW     (CW),
        .OW     (OW),
        .HAS_NB ((r > 0) ? 1 : 0)
      ) u_up (
        .active  (act_w[r]),
        .lidx    (lidx_w[r]),
        .nb_lpos (lpos_w[(r > 0) ? r - 1 : 0]),
        .offs    (vlink_up[r*COLS*OW +: COLS*OW])
      );

      rsr_vlink #(
        .COLS   (COLS),
        .LCOLS  (LCOLS),
        .CW     (CW),
        .OW     (OW),
        .HAS_NB ((r < ROWS - 1) ? 1 : 0)
      ) u_dn (
        .active  (act_w[r]),
        .lidx    (lidx_w[r]),
        .nb_lpos (lpos_w[(r < ROWS - 1) ? r + 1 : r]),
        .offs    (vlink_dn[r*COLS*OW +: COLS*OW])
      );
    end
  endgenerate

  // Sticky failure flag.
  always_comb begin
    fail_en = |row_refuse;
    fail_d  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      fail_q <= 1'b0;
    end else if (fail_en) begin
      fail_q <= fail_d;
    end
  end

  assign dev_failed = fail_q;

endmodule

// File: rtl/rsr_chk.sv
module rsr_chk
  import rsr_pkg::*;
#(
  parameter int ROWS   = DEF_ROWS,
  parameter int COLS   = DEF_COLS,
  parameter int SPARES = DEF_SPARES,
  localparam int RW    = idx_w(ROWS),
  localparam int CW    = idx_w(COLS),
  localparam int SW    = idx_w(SPARES + 1),
  localparam int OW    = SW + 1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    fault_vld,
  input logic [RW-1:0]           fault_row,
  input logic [CW-1:0]           fault_col,
  input logic [ROWS*COLS-1:0]    bypass_sel,
  input logic [ROWS*COLS*OW-1:0] vlink_up,
  input logic [ROWS*COLS*OW-1:0] vlink_dn,
  input logic                    dev_failed
);

  logic out_of_range;
  assign out_of_range = ({1'b0, fault_row} >= (RW+1)'(ROWS)) ||
                        ({1'b0, fault_col} >= (CW+1)'(COLS));

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (bypass_sel == '0 && !dev_failed));

  assert_retire_keeps_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((bypass_sel & $past(bypass_sel)) == $past(bypass_sel)));

  assert_idle_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_vld |=> $stable(bypass_sel));

  assert_single_retire_R3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones(bypass_sel ^ $past(bypass_sel)) <= 1));

  assert_top_row_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    vlink_up[COLS*OW-1:0] == '0);

  assert_bottom_row_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    vlink_dn[ROWS*COLS*OW-1 -: COLS*OW] == '0);

  assert_fail_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dev_failed |=> dev_failed);

  assert_fail_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dev_failed) |-> $past(fault_vld));

  assert_range_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_vld && out_of_range) |=> $stable(bypass_sel));

  genvar r;
  generate
    for (r = 0; r < ROWS; r++) begin : g_budget
      assert_row_budget_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(bypass_sel[r*COLS +: COLS]) <= SPARES);
    end
  endgenerate

endmodule

bind row_spare_remap rsr_chk #(
  .ROWS   (ROWS),
  .COLS   (COLS),
  .SPARES (SPARES)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .fault_vld  (fault_vld),
  .fault_row  (fault_row),
  .fault_col  (fault_col),
  .bypass_sel (bypass_sel),
  .vlink_up   (vlink_up),
  .vlink_dn   (vlink_dn),
  .dev_failed (dev_failed)
);

// File: tb/row_spare_remap_tb_top.sv
`timescale 1ns/1ps
module row_spare_remap_tb_top;

  localparam int ROWS   = 6;
  localparam int COLS   = 6;
  localparam int SPARES = 3;
  localparam int LCOLS  = COLS - SPARES;
  localparam int RW     = 3;
  localparam int CW     = 3;
  localparam int OW     = 3;

  logic                    clk;
  logic                    rst_n;
  logic                    fault_vld;
  logic [RW-1:0]           fault_row;
  logic [CW-1:0]           fault_col;
  logic [ROWS*COLS-1:0]    bypass_sel;
  logic [ROWS*COLS*OW-1:0] vlink_up;
  logic [ROWS*COLS*OW-1:0] vlink_dn;
  logic                    dev_failed;

  int  n_vec;
  int  n_bad;
  bit  done;
  bit  m_ret [ROWS][COLS];
  bit  m_fail;

  row_spare_remap #(.ROWS(ROWS), .COLS(COLS), .SPARES(SPARES)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .fault_vld  (fault_vld),
    .fault_row  (fault_row),
    .fault_col  (fault_col),
    .bypass_sel (bypass_sel),
    .vlink_up   (vlink_up),
    .vlink_dn   (vlink_dn),
    .dev_failed (dev_failed)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // ---------------- reference model ----------------
  function automatic void model_clear();
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        m_ret[r][c] = 1'b0;
    m_fail = 1'b0;
  endfunction

  function automatic int retired_cnt(int r);
    int n = 0;
    for (int c = 0; c < COLS; c++) if (m_ret[r][c]) n++;
    return n;
  endfunction

  function automatic void model_fault(int r, int c);
    if (r >= ROWS || c >= COLS) return;
    if (m_ret[r][c]) return;
    if (retired_cnt(r) == SPARES) m_fail = 1'b1;
    else m_ret[r][c] = 1'b1;
  endfunction

  function automatic int phys_of(int r, int k);
    int n = 0;
    for (int p = 0; p < COLS; p++) begin
      if (!m_ret[r][p]) begin
        if (n == k) return p;
        n++;
      end
    end
    return -1;
  endfunction

  function automatic int logic_of(int r, int p);
    int n = 0;
    if (m_ret[r][p]) return -1;
    for (int q = 0; q < p; q++) if (!m_ret[r][q]) n++;
    return (n < LCOLS) ? n : -1;
  endfunction

  function automatic logic [ROWS*COLS-1:0] exp_bypass();
    logic [ROWS*COLS-1:0] v = '0;
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        v[r*COLS+c] = m_ret[r][c];
    return v;
  endfunction

  function automatic logic [ROWS*COLS*OW-1:0] exp_link(int dir);
    logic [ROWS*COLS*OW-1:0] v = '0;
    for (int r = 0; r < ROWS; r++) begin
      for (int p = 0; p < COLS; p++) begin
        int k  = logic_of(r, p);
        int nb = r + dir;
        if (k >= 0 && nb >= 0 && nb < ROWS)
          v[(r*COLS+p)*OW +: OW] = OW'(phys_of(nb, k) - p);
      end
    end
    return v;
  endfunction

  // ---------------- checking ----------------
  task automatic compare(string tag);
    logic [ROWS*COLS-1:0]    eb = exp_bypass();
    logic [ROWS*COLS*OW-1:0] eu = exp_link(-1);
    logic [ROWS*COLS*OW-1:0] ed = exp_link(1);
    n_vec++;
    if (bypass_sel !== eb) begin
      n_bad++;
      $display("FAIL %s (R4 bypass) got %h exp %h", tag, bypass_sel, eb);
    end
    if (vlink_up !== eu) begin
      n_bad++;
      $display("FAIL %s (R5 vlink_up) got %h exp %h", tag, vlink_up, eu);
    end
    if (vlink_dn !== ed) begin
      n_bad++;
      $display("FAIL %s (R6 vlink_dn) got %h exp %h", tag, vlink_dn, ed);
    end
    if (dev_failed !== m_fail) begin
      n_bad++;
      $display("FAIL %s (R8 dev_failed) got %b exp %b", tag, dev_failed, m_fail);
    end
  endtask

  task automatic apply(bit v, int r, int c, string tag);
    fault_vld = v;
    fault_row = RW'(r);
    fault_col = CW'(c);
    @(posedge clk);
    if (v) model_fault(r, c);
    @(negedge clk);
    fault_vld = 1'b0;
    compare(tag);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) apply(1'b0, 0, 0, tag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    model_clear();
    @(negedge clk);
    compare("R1 in reset");
    @(negedge clk);
    compare("R1 in reset");
    rst_n = 1'b1;
    idle(3, "R1 after release");
  endtask

  initial begin
    n_vec = 0; n_bad = 0; done = 1'b0;
    fault_vld = 1'b0; fault_row = '0; fault_col = '0;
    rst_n = 1'b0;
    model_clear();
    @(negedge clk);
    do_reset();

    apply(1'b1, 2, 1, "R2 first fault row2 col1");
    idle(1, "R3 other rows untouched");
    apply(1'b1, 2, 1, "R9 repeat retired position");
    apply(1'b1, 6, 0, "R10 row out of range");
    apply(1'b1, 1, 7, "R10 col out of range");
    apply(1'b1, 2, 5, "R11 idle spare retired");
    apply(1'b1, 4, 2, "R7 row4 fault a");
    apply(1'b1, 4, 1, "R7 row4 fault b");
    apply(1'b1, 4, 0, "R7 row4 fault c");
    apply(1'b1, 0, 0, "R5 top row shift");
    apply(1'b1, 5, 2, "R6 bottom row shift");
    apply(1'b1, 3, 1, "R3 row between shifted rows");
    apply(1'b1, 2, 0, "R4 last spare of row2");
    apply(1'b1, 2, 3, "R8 fault in full row");
    apply(1'b1, 4, 4, "R8 second refused fault");
    idle(2, "R8 sticky flag");
    apply(1'b1, 1, 2, "R2 fault after failure");

    do_reset();
    apply(1'b1, 3, 0, "R4 leftmost fault");
    apply(1'b1, 3, 3, "R11 spare after shift");
    apply(1'b1, 3, 4, "R4 shifted element retired");
    apply(1'b1, 3, 5, "R8 row3 exhausted");
    idle(2, "R8 hold");

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired (R1) got running exp finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule